// File: doc/BRIEF.md
# Load-Use Stall and Branch Squash Controller

This block is the hazard-steering logic of a five-stage in-order pipeline. Each cycle it looks at the instruction sitting in the execute stage and at the two source register fields of the instruction in decode. If the execute-stage instruction is a load whose destination is one of those sources, the loaded value cannot reach the dependent instruction in time. The block then freezes the program counter and the fetch/decode register for one cycle, so fetch and decode repeat. It also sends a bubble into the decode/execute register by zeroing the control bundle that enters it.

The pipeline predicts every branch as not taken. When the execute stage reports a taken branch, the block flushes the fetch/decode register to a no-op and bubbles the decode/execute register, which squashes both wrongly fetched instructions. The program counter stays free to load the branch target. A squash overrides a simultaneous load-use hold. Forwarding and branch target arithmetic live elsewhere; after the one-cycle bubble, the loaded value reaches the replayed instruction through the forwarding network.

Top module: `lu_stall_ctrl`

## Requirements
- R1: A load-use hit exists only when all three of these hold: `ex_mem_rd` is 1, `ex_rt` is nonzero, and `ex_rt` equals `id_rs` or `id_rt`. Without a hit or a taken branch the block does not stall.
- R2: In a stall cycle (hit and `br_taken` = 0), `pc_we` and `fd_we` are both 0. Both enables are active high.
- R3: In a stall cycle, `dx_bubble` is 1 and `fd_flush` is 0.
- R4: A load whose destination is register 0 never causes a stall, even when a decode source field is also 0.
- R5: With the default setting (all control bits zeroed), `dx_ctrl_out` is all zeros whenever `dx_bubble` is 1. Otherwise `dx_ctrl_out` equals `dx_ctrl_in`. In the partial setting, only the bits set in the write-enable mask are cleared.
- R6: When `br_taken` is 1, `fd_flush` = 1, `dx_bubble` = 1, `pc_we` = 1 and `fd_we` = 1.
- R7: When a taken branch and a load-use hit occur in the same cycle, the outputs are exactly those of R6. The hold is dropped.
- R8: In a pipeline where the bubble clears the execute-stage memory-read bit, a load-use stall lasts exactly one cycle. The instruction held in decode enters execute in the cycle right after the bubble. Instructions fetched behind a taken branch never reach execute.
- R9: With no hit and no taken branch, `pc_we` = 1, `fd_we` = 1, `dx_bubble` = 0 and `fd_flush` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_mem_rd | input | 1 | Execute-stage instruction reads data memory (is a load) |
| ex_rt | input | REG_AW | Destination register of the execute-stage load |
| id_rs | input | REG_AW | First source register field of the decode-stage instruction |
| id_rt | input | REG_AW | Second source register field of the decode-stage instruction |
| br_taken | input | 1 | Execute stage resolved a branch as taken |
| dx_ctrl_in | input | CTRL_W | Control bundle produced by decode |
| pc_we | output | 1 | Program counter write enable, active high |
| fd_we | output | 1 | Fetch/decode register write enable, active high |
| dx_bubble | output | 1 | Select that zeroes the control bundle entering decode/execute |
| fd_flush | output | 1 | Clears the fetch/decode register to a no-op |
| dx_ctrl_out | output | CTRL_W | Control bundle after the bubble select, into decode/execute |

## Verification
The block is purely combinational, so a wrong decision shows on the enables in the very cycle the inputs present it. The effect on the instruction stream appears only one or two cycles later. A comparator that misses a source field lets a dependent instruction advance without its hold, and the pipeline trace then lacks the bubble before that instruction. A wrongly kept hold, or a hold that wins over a squash, makes the trace repeat an instruction, or lets a squashed one reach execute on the next cycle. The bench therefore checks every output against its reference every cycle, and also checks the execute-stage trace of a short program cycle by cycle.

// File: rtl/lu_pkg.sv
package lu_pkg;

  // Decision taken by the controller in one cycle.
  typedef enum logic [1:0] {
    ACT_RUN    = 2'd0,
    ACT_HOLD   = 2'd1,
    ACT_SQUASH = 2'd2
  } lu_act_e;

  // Steering outputs derived from a decision.
  typedef struct packed {
    logic pc_we;
    logic fd_we;
    logic bubble;
    logic flush;
  } lu_steer_t;

  // A taken branch outranks a load-use hold.
  function automatic lu_act_e pick_act(input logic hit, input logic taken);
    if (taken)
      return ACT_SQUASH;
    else if (hit)
      return ACT_HOLD;
    else
      return ACT_RUN;
  endfunction

  function automatic lu_steer_t steer_of(input lu_act_e act);
    lu_steer_t s;
    case (act)
      ACT_HOLD:   s = '{pc_we: 1'b0, fd_we: 1'b0, bubble: 1'b1, flush: 1'b0};
      ACT_SQUASH: s = '{pc_we: 1'b1, fd_we: 1'b1, bubble: 1'b1, flush: 1'b1};
      default:    s = '{pc_we: 1'b1, fd_we: 1'b1, bubble: 1'b0, flush: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic                     ex_mem_rd,
  input  logic [REG_AW-1:0]        ex_rt,
  input  logic [NSRC*REG_AW-1:0]   src_flat,
  output logic                     hit
);

  localparam int SRC_W = NSRC * REG_AW;

  // A destination of register zero is never a real producer.
  function automatic logic dest_live(input logic [REG_AW-1:0] r);
    return |r;
  endfunction

  logic [NSRC-1:0] src_hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [REG_AW-1:0] src_r;
    assign src_r      = src_flat[g*REG_AW +: REG_AW];
    assign src_hit[g] = (src_r == ex_rt);
  end

  logic unused_w;
  assign unused_w = (SRC_W == 0);

  assign hit = ex_mem_rd && dest_live(ex_rt) && (|src_hit) && !unused_w;

endmodule

// File: rtl/lu_stall_arbiter.sv
module lu_stall_arbiter
  import lu_pkg::*;
(
  input  logic    hit,
  input  logic    taken,
  output lu_act_e act,
  output logic    pc_we,
  output logic    fd_we,
  output logic    bubble,
  output logic    flush
);

  lu_steer_t steer;

  always_comb begin
    act   = pick_act(hit, taken);
    steer = steer_of(act);
  end

  assign pc_we  = steer.pc_we;
  assign fd_we  = steer.fd_we;
  assign bubble = steer.bubble;
  assign flush  = steer.flush;

endmodule

// File: rtl/lu_bubble_mux.sv
module lu_bubble_mux #(
  parameter int                CTRL_W   = 8,
  parameter bit                ZERO_ALL = 1'b1,
  parameter logic [CTRL_W-1:0] WR_MASK  = 'b11
) (
  input  logic              bubble,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out
);

  // Bits that survive a bubble: none when zeroing everything,
  // otherwise everything except the write enables.
  localparam logic [CTRL_W-1:0] KEEP_MASK = ZERO_ALL ? '0 : ~WR_MASK;

  function automatic logic [CTRL_W-1:0] squash(input logic [CTRL_W-1:0] c);
    return c & KEEP_MASK;
  endfunction

  assign ctrl_out = bubble ? squash(ctrl_in) : ctrl_in;

endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
  import lu_pkg::*;
#(
  parameter int                REG_AW   = 5,
  parameter int                CTRL_W   = 8,
  parameter bit                ZERO_ALL = 1'b1,
  parameter logic [CTRL_W-1:0] WR_MASK  = 'b11
) (
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              br_taken,
  input  logic [CTRL_W-1:0] dx_ctrl_in,
  output logic              pc_we,
  output logic              fd_we,
  output logic              dx_bubble,
  output logic              fd_flush,
  output logic [CTRL_W-1:0] dx_ctrl_out
);

  localparam int NSRC = 2;

  // Named internal events, visible to the bound checker.
  logic    load_use_hit;
  lu_act_e act;

  lu_hazard_detect #(
    .REG_AW (REG_AW),
    .NSRC   (NSRC)
  ) u_det (
    .ex_mem_rd (ex_mem_rd),
    .ex_rt     (ex_rt),
    .src_flat  ({id_rt, id_rs}),
    .hit       (load_use_hit)
  );

  lu_stall_arbiter u_arb (
    .hit    (load_use_hit),
    .taken  (br_taken),
    .act    (act),
    .pc_we  (pc_we),
    .fd_we  (fd_we),
    .bubble (dx_bubble),
    .flush  (fd_flush)
  );

  lu_bubble_mux #(
    .CTRL_W   (CTRL_W),
    .ZERO_ALL (ZERO_ALL),
    .WR_MASK  (WR_MASK)
  ) u_mux (
    .bubble   (dx_bubble),
    .ctrl_in  (dx_ctrl_in),
    .ctrl_out (dx_ctrl_out)
  );

endmodule

// File: rtl/lu_stall_ctrl_chk.sv
module lu_stall_ctrl_chk
  import lu_pkg::*;
#(
  parameter int                REG_AW   = 5,
  parameter int                CTRL_W   = 8,
  parameter bit                ZERO_ALL = 1'b1,
  parameter logic [CTRL_W-1:0] WR_MASK  = 'b11
) (
  input logic              ex_mem_rd,
  input logic [REG_AW-1:0] ex_rt,
  input logic              br_taken,
  input logic              pc_we,
  input logic              fd_we,
  input logic              dx_bubble,
  input logic              fd_flush,
  input logic [CTRL_W-1:0] dx_ctrl_in,
  input logic [CTRL_W-1:0] dx_ctrl_out,
  input logic              load_use_hit,
  input lu_act_e           act
);

  localparam bit ALL = ZERO_ALL;

  always_comb begin
    a_r1_needs_load: assert (ex_mem_rd || pc_we)
      else $error("R1: hold without a load in execute");
    a_r2_hold_enables: assert (!(load_use_hit && !br_taken) || (!pc_we && !fd_we))
      else $error("R2: enables not dropped on load-use");
    a_r3_bubble_on_hold: assert (pc_we || (dx_bubble && !fd_flush))
      else $error("R3: hold without clean bubble");
    a_r4_zero_dest: assert (ex_rt != '0 || pc_we)
      else $error("R4: hold on register zero");
    a_r5_write_bits_clear: assert (!dx_bubble || (dx_ctrl_out & WR_MASK) == '0)
      else $error("R5: write bits survive a bubble");
    a_r5_all_clear: assert (!dx_bubble || !ALL || dx_ctrl_out == '0)
      else $error("R5: control not cleared");
    a_r5_pass: assert (dx_bubble || dx_ctrl_out == dx_ctrl_in)
      else $error("R5: control altered without bubble");
    a_r6_squash: assert (!br_taken || (fd_flush && dx_bubble && pc_we && fd_we))
      else $error("R6: taken branch not squashed");
    a_r7_squash_wins: assert (!(br_taken && load_use_hit) || act == ACT_SQUASH)
      else $error("R7: hold beat a squash");
    a_r9_quiet: assert (dx_bubble || (pc_we && fd_we && !fd_flush))
      else $error("R9: steering without cause");
  end

endmodule

bind lu_stall_ctrl lu_stall_ctrl_chk #(
  .REG_AW   (REG_AW),
  .CTRL_W   (CTRL_W),
  .ZERO_ALL (ZERO_ALL),
  .WR_MASK  (WR_MASK)
) u_chk (
  .ex_mem_rd    (ex_mem_rd),
  .ex_rt        (ex_rt),
  .br_taken     (br_taken),
  .pc_we        (pc_we),
  .fd_we        (fd_we),
  .dx_bubble    (dx_bubble),
  .fd_flush     (fd_flush),
  .dx_ctrl_in   (dx_ctrl_in),
  .dx_ctrl_out  (dx_ctrl_out),
  .load_use_hit (load_use_hit),
  .act          (act)
);

// File: tb/sim_lu_stall_ctrl.sv
module sim_lu_stall_ctrl;
  localparam int AW = 5;
  localparam int CW = 8;
  localparam int NP = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          ex_mem_rd  = 1'b0;
  logic [AW-1:0] ex_rt      = '0;
  logic [AW-1:0] id_rs      = '0;
  logic [AW-1:0] id_rt      = '0;
  logic          br_taken   = 1'b0;
  logic [CW-1:0] dx_ctrl_in = '0;
  logic          pc_we, fd_we, dx_bubble, fd_flush;
  logic [CW-1:0] dx_ctrl_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  lu_stall_ctrl u0 (
    .ex_mem_rd   (ex_mem_rd),
    .ex_rt       (ex_rt),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .br_taken    (br_taken),
    .dx_ctrl_in  (dx_ctrl_in),
    .pc_we       (pc_we),
    .fd_we       (fd_we),
    .dx_bubble   (dx_bubble),
    .fd_flush    (fd_flush),
    .dx_ctrl_out (dx_ctrl_out)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Reference: returns {pc_we, fd_we, bubble, flush}.
  function automatic int ref_steer(bit ld, int ert, int irs, int irt, bit br);
    int  srcs[2];
    bit  dep = 1'b0;
    srcs = '{irs, irt};
    foreach (srcs[i])
      if (ld && ert != 0 && srcs[i] == ert) dep = 1'b1;
    if (br)  return 4'b1111;
    if (dep) return 4'b0010;
    return 4'b1100;
  endfunction

  task automatic compare_all(input string req);
    int e;
    int ec;
    e  = ref_steer(ex_mem_rd, int'(ex_rt), int'(id_rs), int'(id_rt), br_taken);
    ec = e[1] ? 0 : int'(dx_ctrl_in);
    chk(req, "pc_we",     int'(pc_we),       e[3]);
    chk(req, "fd_we",     int'(fd_we),       e[2]);
    chk(req, "dx_bubble", int'(dx_bubble),   e[1]);
    chk(req, "fd_flush",  int'(fd_flush),    e[0]);
    chk(req, "ctrl_out",  int'(dx_ctrl_out), ec);
  endtask

  task automatic apply(input string req, input bit ld, input int ert, input int irs,
                       input int irt, input bit br, input int ctrl);
    @(negedge clk);
    ex_mem_rd  = ld;
    ex_rt      = AW'(ert);
    id_rs      = AW'(irs);
    id_rt      = AW'(irt);
    br_taken   = br;
    dx_ctrl_in = CW'(ctrl);
    #2;
    compare_all(req);
  endtask

  // Program for the pipeline model.
  int p_ld [NP];
  int p_rs [NP];
  int p_rt [NP];
  int p_br [NP];
  int p_tg [NP];
  int trace[$];
  int exp_trace[16] = '{-1, -1, 0, -1, 1, 2, 3, 4, 5, -1, 6, 7, -1, -1, 10, 11};

  initial begin
    foreach (p_ld[i]) begin
      p_ld[i] = 0; p_rs[i] = 1; p_rt[i] = 2; p_br[i] = 0; p_tg[i] = 0;
    end
    p_ld[0] = 1; p_rs[0] = 5; p_rt[0] = 4;  // load into r4
    p_rs[1] = 4; p_rt[1] = 7;               // uses r4 as first source
    p_ld[3] = 1; p_rs[3] = 5; p_rt[3] = 0;  // load into r0
    p_rs[4] = 0; p_rt[4] = 0;               // reads r0 only
    p_ld[5] = 1; p_rs[5] = 3; p_rt[5] = 7;  // load into r7
    p_rs[6] = 9; p_rt[6] = 7;               // uses r7 as second source
    p_br[7] = 1; p_tg[7] = 10;              // taken branch
    p_ld[8] = 1; p_rt[8] = 2;               // squashed
  end

  task automatic run_pipeline();
    int pc = 0;
    int fd = -1;
    int dx = -1;
    int holds = 0;
    int squashes = 0;
    for (int cyc = 0; cyc < 16; cyc++) begin
      int dx_n, fd_n, pc_n, fetched;
      @(negedge clk);
      ex_mem_rd  = (dx >= 0) && p_ld[dx] != 0;
      ex_rt      = (dx >= 0) ? AW'(p_rt[dx]) : '0;
      br_taken   = (dx >= 0) && p_br[dx] != 0;
      id_rs      = (fd >= 0) ? AW'(p_rs[fd]) : '0;
      id_rt      = (fd >= 0) ? AW'(p_rt[fd]) : '0;
      dx_ctrl_in = CW'(8'hA5);
      #2;
      compare_all("R8");
      trace.push_back(dx);
      if (!pc_we) holds++;
      if (fd_flush) squashes++;
      fetched = (pc < NP) ? pc : -1;
      dx_n = dx_bubble ? -1 : fd;
      fd_n = fd_flush ? -1 : (fd_we ? fetched : fd);
      pc_n = !pc_we ? pc : (br_taken ? p_tg[dx] : pc + 1);
      dx = dx_n; fd = fd_n; pc = pc_n;
    end
    foreach (exp_trace[i])
      chk("R8", $sformatf("execute slot cycle %0d", i), trace[i], exp_trace[i]);
    chk("R8", "hold cycles", holds, 2);
    chk("R8", "squash cycles", squashes, 1);
  endtask

  initial begin
    // Idle state with all inputs zero.
    #2;
    chk("R9", "idle pc_we", int'(pc_we), 1);
    chk("R9", "idle fd_we", int'(fd_we), 1);
    chk("R9", "idle bubble", int'(dx_bubble), 0);
    chk("R9", "idle flush", int'(fd_flush), 0);

    apply("R9", 0, 0, 0, 0, 0, 8'h3C);
    apply("R1", 1, 3, 3, 6, 0, 8'hFF);   // match on first source
    chk("R2", "pc_we held", int'(pc_we), 0);
    chk("R3", "bubble set", int'(dx_bubble), 1);
    chk("R5", "ctrl zeroed", int'(dx_ctrl_out), 0);
    apply("R1", 1, 3, 6, 3, 0, 8'h81);   // match on second source
    apply("R4", 1, 0, 0, 0, 0, 8'hFF);   // register zero
    chk("R4", "no hold on r0", int'(pc_we), 1);
    apply("R1", 0, 3, 3, 3, 0, 8'h11);   // not a load
    apply("R1", 1, 3, 4, 5, 0, 8'h22);   // no field match
    apply("R6", 0, 0, 1, 2, 1, 8'hF0);   // taken branch alone
    chk("R6", "flush", int'(fd_flush), 1);
    apply("R7", 1, 9, 9, 9, 1, 8'h0F);   // branch and hit together
    chk("R7", "pc_we free", int'(pc_we), 1);
    chk("R7", "fd_we free", int'(fd_we), 1);
    apply("R5", 0, 2, 2, 2, 0, 8'h5A);   // passes unchanged
    chk("R5", "ctrl passes", int'(dx_ctrl_out), 8'h5A);

    run_pipeline();

    // Random sweep over a narrow register range to hit matches often.
    for (int k = 0; k < 300; k++) begin
      apply("R1", bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            bit'($urandom_range(0, 4) == 0), int'($urandom_range(0, 255)));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule